// File: doc/BRIEF.md
# System Controller Register Block

This block is the word-addressed register file of a small system controller. A host reaches it through a simple single-cycle read/write port that carries a byte address, a write enable and 32-bit data. The block holds a free scratch word, a general-purpose output word, and a GPIO input word preset from strap values. It also holds read-only words for system identity, clock rate and capability flags, which load from parameters at reset. A configuration-port word reads back a ready flag and takes commands. A reset-trigger word raises a system reset request when written.

Read data, the error pulse and the two request outputs are registered. They appear in the clock cycle after the access. Read data holds its value until the next read. Any access to an unmapped, misaligned or read-only-for-write location raises a one-cycle error pulse and sets a sticky status bit that software clears.

Word map (byte address = word index × 4): 0x00 GPIO input (RO), 0x04 GPIO output (RW), 0x08 error status, 0x20 configuration port, 0x50 scratch (RW), 0x54 reset trigger, 0x74 clock rate (RO), 0x78 capabilities (RO), 0x7C system identity (RO). Every other address is unmapped.

Top module: `sysCtrlRegs`

## Requirements
- R1: After reset, reads return these values: GPIO input = STRAPS (default 0x00000001), identity = SYS_ID (default 0x10014D31), clock rate = CLK_HZ, capabilities = CAPS, configuration port = 0x00000001 (bit 0 is the ready flag), and zero for GPIO output, scratch and error status.
- R2: The scratch word at 0x50 stores all 32 bits written. A read returns its value on busRdata one cycle after the access, and busRdata holds until the next read.
- R3: The GPIO output word at 0x04 stores all 32 bits written and reads them back.
- R4: A write to GPIO input, clock rate, capabilities or identity changes nothing and raises errPulse.
- R5: A read from an unmapped word returns zero and raises errPulse. A write to an unmapped word raises errPulse and changes no register.
- R6: errPulse is high for exactly the one cycle after each bad access and is low after every good access and every idle cycle.
- R7: Error status bit 0 (at 0x08) sets on any bad access. Writing 1 to bit 0 clears it. Writing 0 to bit 0 leaves it unchanged.
- R8: A write to the configuration port whose low 16 bits equal SHUTDOWN_CMD (default 0x000E) raises shutdownReq for one cycle, whatever the upper 16 bits are. Any other value raises nothing.
- R9: A write to the reset trigger at 0x54 raises resetReq for one cycle. A read of it returns zero and raises no request and no error.
- R10: An access whose byte address has either of its two low bits set is a bad access. A read returns zero and a write changes nothing, and both raise errPulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Access strobe, one access per cycle |
| busWe | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid the cycle after a read |
| errPulse | output | 1 | One-cycle bad-access indication |
| resetReq | output | 1 | One-cycle system reset request |
| shutdownReq | output | 1 | One-cycle shutdown request |

## Verification
The assertions assume a single host that issues at most one access per cycle. They also assume the host holds busSel low while reset is asserted, because every registered output is checked against the bus state one cycle earlier. The stimulus follows these rules: it drives the bus only on falling edges and keeps busSel low during reset. It places idle cycles between accesses where a pulse has to be seen falling, and it uses back-to-back accesses elsewhere.

// File: rtl/sysRegPkg.sv
package sysRegPkg;
  localparam int DATA_W = 32;
  localparam int IDX_W  = 5;

  localparam logic [IDX_W-1:0] IDX_GPIO_IN  = 5'd0;
  localparam logic [IDX_W-1:0] IDX_GPIO_OUT = 5'd1;
  localparam logic [IDX_W-1:0] IDX_ERRSTAT  = 5'd2;
  localparam logic [IDX_W-1:0] IDX_CFG      = 5'd8;
  localparam logic [IDX_W-1:0] IDX_SCRATCH  = 5'd20;
  localparam logic [IDX_W-1:0] IDX_RSTTRIG  = 5'd21;
  localparam logic [IDX_W-1:0] IDX_CLK      = 5'd29;
  localparam logic [IDX_W-1:0] IDX_CAPS     = 5'd30;
  localparam logic [IDX_W-1:0] IDX_SYSID    = 5'd31;

  typedef enum logic [3:0] {
    SRC_ZERO, SRC_GPIO_IN, SRC_GPIO_OUT, SRC_ERR, SRC_CFG,
    SRC_SCRATCH, SRC_CLK, SRC_CAPS, SRC_SYSID
  } rdSrc_t;

  typedef enum logic [2:0] {
    K_UNMAP, K_RO, K_GPIO_OUT, K_SCRATCH, K_ERRSTAT, K_CFG, K_RSTTRIG
  } kind_t;

  typedef struct packed {
    logic   rdEn;
    rdSrc_t rdSrc;
    logic   wrGpioOut;
    logic   wrScratch;
    logic   clrErr;
    logic   setErr;
  } strobe_t;
endpackage

// File: rtl/sysRegCtrl.sv
module sysRegCtrl
  import sysRegPkg::*;
#(
  parameter int          ADDR_W       = 8,
  parameter logic [15:0] SHUTDOWN_CMD = 16'h000E
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [15:0]       cfgCmd,
  output strobe_t           strb,
  output logic              errPulse,
  output logic              resetReq,
  output logic              shutdownReq
);
  localparam int LO_W = IDX_W + 2;

  logic             hiZero;
  logic             aligned;
  logic [IDX_W-1:0] idx;
  kind_t            kind;
  rdSrc_t           src;
  logic             rstHit;
  logic             shutHit;

  generate
    if (ADDR_W > LO_W) begin : g_hi
      assign hiZero = ~|busAddr[ADDR_W-1:LO_W];
    end else begin : g_nohi
      assign hiZero = 1'b1;
    end
  endgenerate

  assign aligned = (busAddr[1:0] == 2'b00);
  assign idx     = busAddr[LO_W-1:2];

  always_comb begin
    kind = K_UNMAP;
    src  = SRC_ZERO;
    if (hiZero && aligned) begin
      case (idx)
        IDX_GPIO_IN:  begin kind = K_RO;        src = SRC_GPIO_IN;  end
        IDX_GPIO_OUT: begin kind = K_GPIO_OUT;  src = SRC_GPIO_OUT; end
        IDX_ERRSTAT:  begin kind = K_ERRSTAT;   src = SRC_ERR;      end
        IDX_CFG:      begin kind = K_CFG;       src = SRC_CFG;      end
        IDX_SCRATCH:  begin kind = K_SCRATCH;   src = SRC_SCRATCH;  end
        IDX_RSTTRIG:  begin kind = K_RSTTRIG;   src = SRC_ZERO;     end
        IDX_CLK:      begin kind = K_RO;        src = SRC_CLK;      end
        IDX_CAPS:     begin kind = K_RO;        src = SRC_CAPS;     end
        IDX_SYSID:    begin kind = K_RO;        src = SRC_SYSID;    end
        default:      begin kind = K_UNMAP;     src = SRC_ZERO;     end
      endcase
    end
  end

  always_comb begin
    strb.rdEn      = busSel && !busWe;
    strb.rdSrc     = src;
    strb.wrGpioOut = busSel && busWe && (kind == K_GPIO_OUT);
    strb.wrScratch = busSel && busWe && (kind == K_SCRATCH);
    strb.clrErr    = busSel && busWe && (kind == K_ERRSTAT);
    strb.setErr    = busSel && ((kind == K_UNMAP) || (busWe && (kind == K_RO)));
  end

  assign rstHit  = busSel && busWe && (kind == K_RSTTRIG);
  assign shutHit = busSel && busWe && (kind == K_CFG) && (cfgCmd == SHUTDOWN_CMD);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errPulse    <= 1'b0;
      resetReq    <= 1'b0;
      shutdownReq <= 1'b0;
    end else begin
      errPulse    <= strb.setErr;
      resetReq    <= rstHit;
      shutdownReq <= shutHit;
    end
  end

  // R6
  errAfterAccess_chk: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> $past(busSel));

  // R9
  resetAfterWrite_chk: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> ($past(busSel) && $past(busWe)));

  // R8
  shutdownCmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    shutdownReq |-> ($past(cfgCmd) == SHUTDOWN_CMD && $past(busWe)));

  // R9
  requestsExclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones({errPulse, resetReq, shutdownReq}) <= 1);
endmodule

// File: rtl/sysRegData.sv
module sysRegData
  import sysRegPkg::*;
#(
  parameter logic [31:0] SYS_ID = 32'h10014D31,
  parameter logic [31:0] CLK_HZ = 32'd80_000_000,
  parameter logic [31:0] CAPS   = 32'h0000_0000,
  parameter logic [31:0] STRAPS = 32'h0000_0001
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] busRdata
);
  localparam int RO_N = 3;
  localparam logic [DATA_W-1:0] RO_INIT [RO_N] = '{CLK_HZ, CAPS, SYS_ID};
  localparam logic [DATA_W-1:0] CFG_READY = {{(DATA_W-1){1'b0}}, 1'b1};

  logic [DATA_W-1:0] roBank [RO_N];
  logic [DATA_W-1:0] gpioInQ;
  logic [DATA_W-1:0] gpioOutQ;
  logic [DATA_W-1:0] scratchQ;
  logic              errStickyQ;
  logic [DATA_W-1:0] rdMux;

  generate
    for (genvar g = 0; g < RO_N; g++) begin : g_ro
      always_ff @(posedge clk) begin
        if (!rstN) roBank[g] <= RO_INIT[g];
        else       roBank[g] <= roBank[g];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gpioInQ    <= STRAPS;
      gpioOutQ   <= '0;
      scratchQ   <= '0;
      errStickyQ <= 1'b0;
    end else begin
      if (strb.wrGpioOut) gpioOutQ <= wdata;
      if (strb.wrScratch) scratchQ <= wdata;
      if (strb.setErr)                 errStickyQ <= 1'b1;
      else if (strb.clrErr && wdata[0]) errStickyQ <= 1'b0;
    end
  end

  always_comb begin
    case (strb.rdSrc)
      SRC_GPIO_IN:  rdMux = gpioInQ;
      SRC_GPIO_OUT: rdMux = gpioOutQ;
      SRC_ERR:      rdMux = {{(DATA_W-1){1'b0}}, errStickyQ};
      SRC_CFG:      rdMux = CFG_READY;
      SRC_SCRATCH:  rdMux = scratchQ;
      SRC_CLK:      rdMux = roBank[0];
      SRC_CAPS:     rdMux = roBank[1];
      SRC_SYSID:    rdMux = roBank[2];
      default:      rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)          busRdata <= '0;
    else if (strb.rdEn) busRdata <= rdMux;
  end

  // R2
  rdataHold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strb.rdEn) |-> $stable(busRdata));

  // R7
  stickyRise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errStickyQ) |-> $past(strb.setErr));

  // R7
  stickyFall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(errStickyQ) |-> ($past(strb.clrErr) && $past(wdata[0])));

  // R3
  gpioOutWrite_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strb.wrGpioOut) |-> $stable(gpioOutQ));
endmodule

// File: rtl/sysCtrlRegs.sv
module sysCtrlRegs
  import sysRegPkg::*;
#(
  parameter int          ADDR_W       = 8,
  parameter logic [31:0] SYS_ID       = 32'h10014D31,
  parameter logic [31:0] CLK_HZ       = 32'd80_000_000,
  parameter logic [31:0] CAPS         = 32'h0000_0000,
  parameter logic [31:0] STRAPS       = 32'h0000_0001,
  parameter logic [15:0] SHUTDOWN_CMD = 16'h000E
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              errPulse,
  output logic              resetReq,
  output logic              shutdownReq
);
  strobe_t strb;

  sysRegCtrl #(.ADDR_W(ADDR_W), .SHUTDOWN_CMD(SHUTDOWN_CMD)) uCtrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWe(busWe),
    .busAddr(busAddr), .cfgCmd(busWdata[15:0]), .strb(strb),
    .errPulse(errPulse), .resetReq(resetReq), .shutdownReq(shutdownReq)
  );

  sysRegData #(.SYS_ID(SYS_ID), .CLK_HZ(CLK_HZ), .CAPS(CAPS), .STRAPS(STRAPS)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .wdata(busWdata), .busRdata(busRdata)
  );
endmodule

// File: tb/sim_sysCtrlRegs.sv
module sim_sysCtrlRegs;
  localparam logic [31:0] E_SYSID = 32'h10014D31;
  localparam logic [31:0] E_CLK   = 32'd80_000_000;
  localparam logic [31:0] E_CAPS  = 32'h0;
  localparam logic [31:0] E_STRAP = 32'h1;
  localparam logic [15:0] E_SHUT  = 16'h000E;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busSel = 1'b0, busWe = 1'b0;
  logic [7:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic errPulse, resetReq, shutdownReq;

  int vectors = 0;
  int fails = 0;

  logic [31:0] mGpioOut = 0, mScratch = 0, expRd = 0;
  bit mSticky = 0, expErr = 0, expRst = 0, expShut = 0;

  always #10 clk = ~clk;

  sysCtrlRegs u0 (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .errPulse(errPulse),
    .resetReq(resetReq), .shutdownReq(shutdownReq)
  );

  task automatic step(input bit sel, input bit we, input logic [7:0] addr,
                      input logic [31:0] wd, input string tag);
    bit bad;
    bit ro;
    bit mapped;
    logic [31:0] rv;
    busSel = sel; busWe = we; busAddr = addr; busWdata = wd;
    bad = 0; ro = 0; mapped = 1; rv = 0;
    case (addr)
      8'h00: begin rv = E_STRAP; ro = 1; end
      8'h04: rv = mGpioOut;
      8'h08: rv = {31'b0, mSticky};
      8'h20: rv = 32'h1;
      8'h50: rv = mScratch;
      8'h54: rv = 0;
      8'h74: begin rv = E_CLK; ro = 1; end
      8'h78: begin rv = E_CAPS; ro = 1; end
      8'h7C: begin rv = E_SYSID; ro = 1; end
      default: mapped = 0;
    endcase
    @(posedge clk);
    expErr = 0; expRst = 0; expShut = 0;
    if (sel) begin
      bad = !mapped || (we && ro);
      expErr = bad;
      if (!we) expRd = rv;
      if (we && mapped) begin
        if (addr == 8'h04) mGpioOut = wd;
        if (addr == 8'h50) mScratch = wd;
        if (addr == 8'h08 && wd[0]) mSticky = 0;
        if (addr == 8'h54) expRst = 1;
        if (addr == 8'h20 && wd[15:0] == E_SHUT) expShut = 1;
      end
      if (bad) mSticky = 1;
    end
    @(negedge clk);
    vectors++;
    if (busRdata !== expRd || errPulse !== expErr || resetReq !== expRst ||
        shutdownReq !== expShut) begin
      fails++;
      $display("FAIL %s: rdata=%h err=%b rst=%b shut=%b expected rdata=%h err=%b rst=%b shut=%b",
               tag, busRdata, errPulse, resetReq, shutdownReq, expRd, expErr, expRst, expShut);
    end
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    step(1, 0, a, 32'h0, tag);
  endtask
  task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag);
    step(1, 1, a, d, tag);
  endtask
  task automatic idle(input string tag);
    step(0, 0, 8'h0, 32'h0, tag);
  endtask

  initial begin
    #(20ns * 5000);
    fails++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset values
    idle("R1 idle after reset");
    rd(8'h00, "R1 gpio in strap");
    rd(8'h7C, "R1 system id");
    rd(8'h74, "R1 clock rate");
    rd(8'h78, "R1 capabilities");
    rd(8'h20, "R1 cfg ready");
    rd(8'h04, "R1 gpio out zero");
    rd(8'h50, "R1 scratch zero");
    rd(8'h08, "R1 err status zero");
    // R2 scratch
    wr(8'h50, 32'hDEADBEEF, "R2 write scratch");
    rd(8'h50, "R2 read scratch");
    idle("R2 rdata holds");
    wr(8'h50, 32'h12345678, "R2 rewrite scratch");
    idle("R2 rdata holds after write");
    rd(8'h50, "R2 read scratch again");
    // R3 gpio out
    wr(8'h04, 32'hA5A5_0F0F, "R3 write gpio out");
    rd(8'h04, "R3 read gpio out");
    // R4 read-only writes
    wr(8'h7C, 32'h0, "R4 write system id");
    idle("R6 pulse drops");
    rd(8'h7C, "R4 system id unchanged");
    wr(8'h74, 32'hFFFF_FFFF, "R4 write clock rate");
    wr(8'h78, 32'h1234, "R4 write caps");
    wr(8'h00, 32'hFFFF_0000, "R4 write gpio in");
    rd(8'h74, "R4 clock rate unchanged");
    rd(8'h78, "R4 caps unchanged");
    rd(8'h00, "R4 gpio in unchanged");
    // R7 sticky
    rd(8'h08, "R7 sticky set");
    wr(8'h08, 32'hFFFF_FFFE, "R7 write bit0 zero");
    rd(8'h08, "R7 sticky still set");
    wr(8'h08, 32'h1, "R7 clear");
    rd(8'h08, "R7 sticky cleared");
    // R5 unmapped
    rd(8'h14, "R5 unmapped read");
    idle("R6 idle after bad read");
    wr(8'hA0, 32'hCAFE_F00D, "R5 unmapped write");
    wr(8'h0C, 32'hCAFE_F00D, "R5 unmapped write low");
    rd(8'h50, "R5 scratch untouched");
    rd(8'h04, "R5 gpio out untouched");
    rd(8'h08, "R7 set by unmapped");
    // R8 shutdown
    wr(8'h20, 32'hABCD_000E, "R8 shutdown cmd");
    idle("R8 shutdown one cycle");
    wr(8'h20, 32'h0000_000F, "R8 other cmd");
    wr(8'h20, 32'h000E_0000, "R8 upper half only");
    // R9 reset trigger
    wr(8'h54, 32'h0, "R9 reset request");
    idle("R9 reset one cycle");
    rd(8'h54, "R9 read trigger");
    // R10 misaligned
    rd(8'h52, "R10 misaligned read");
    wr(8'h51, 32'h0BAD_0BAD, "R10 misaligned write");
    rd(8'h50, "R10 scratch untouched");
    idle("R6 final idle");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule